// File: doc/BRIEF.md
# Double-Edge Interface Pattern Checker

This block verifies the data capture of a two-bus, double-data-rate sample interface by comparing the received words against an eight-word reference key held in configuration ports. Each bus carries one word per data-clock edge. The block receives this as a rising-edge word and a falling-edge word per system clock for each bus. A frame marker starts the comparison. The marker is either a strobe line or a sync line, chosen by a select port.

After the marker, bus A is expected to carry key words 0, 1, 4, 5 and bus B key words 2, 3, 6, 7. Each system clock consumes two of those positions per bus, so one frame spans two system clocks and repeats with no further marker. Any mismatched bit, on either bus, sets the bit in the same position of a sticky 16-bit error mask and sets a sticky summary alarm. While the test is enabled, the block asks for the analog outputs to be disabled and marks every other alarm source as not valid.

Top module: `ddr_pattern_checker`

## Requirements
- R1: Key word k is taken from `key_words[16k+15:16k]`. In frame half 0, bus A rise/fall must equal words 0/1 and bus B rise/fall words 2/3. In frame half 1, bus A must equal words 4/5 and bus B words 6/7.
- R2: With `marker_sel` = 0 the strobe input is the frame marker, and with `marker_sel` = 1 the sync input is. The unselected input has no effect.
- R3: The cycle in which the selected marker goes from low to high while enabled is frame half 0. Before the first such edge after enable, no error is recorded.
- R4: After the first marker edge, the halves alternate 0, 1, 0, 1 on every system clock for as long as enable stays high, with no further marker.
- R5: A later low-to-high marker edge restarts the frame at half 0 in that cycle. A marker held high does not restart it.
- R6: `err_mask` bit i becomes 1 in the cycle after bit i mismatches in any of the four compared words. It stays 1 until a wipe.
- R7: `alarm` becomes 1 with the first recorded mismatch and stays 1 until a wipe.
- R8: A high `clear`, or a low-to-high change of `test_en`, zeroes the mask and alarm in the next cycle and disarms the frame until a new marker edge.
- R9: `analog_off` equals `test_en`, and `other_alarms_valid` equals its inverse.
- R10: While `test_en` is low, no comparison happens and the mask and alarm hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Test enable |
| marker_sel | input | 1 | 0 = strobe marker, 1 = sync marker |
| strobe_in | input | 1 | Strobe marker line |
| sync_in | input | 1 | Sync marker line |
| clear | input | 1 | Synchronous wipe of results and frame |
| key_words | input | 128 | Eight 16-bit key words, word k at bits 16k+15:16k |
| bus_a_rise | input | 16 | Bus A word captured on the rising data edge |
| bus_a_fall | input | 16 | Bus A word captured on the falling data edge |
| bus_b_rise | input | 16 | Bus B word captured on the rising data edge |
| bus_b_fall | input | 16 | Bus B word captured on the falling data edge |
| err_mask | output | 16 | Sticky per-bit-position error mask |
| alarm | output | 1 | Sticky summary alarm |
| analog_off | output | 1 | Request to force the analog outputs off |
| other_alarms_valid | output | 1 | Low while the test masks other alarms |

## Verification
The bench sweeps every bit position against every key slot, on both marker types and in both frame halves, including repeats long after the marker. A design that swapped the interleave order or mapped a slot to the wrong bit would flag the wrong bit or none. A continuously high marker and a marker pulsed mid-frame are the cases that separate level-triggered or non-restarting designs from correct ones: either fault shows up as spurious errors on correct data. Errors injected before the first marker, on the unselected marker line and while disabled must leave the mask unchanged. A design that compared too early or ignored the select field would latch those errors.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;

    typedef enum logic {
        MKR_STROBE = 1'b0,
        MKR_SYNC   = 1'b1
    } marker_sel_e;

    typedef struct packed {
        logic en_prev;
        logic armed;
        logic phase;
    } seq_state_t;

    localparam int unsigned LANES      = 2;
    localparam int unsigned EDGES      = 2;
    localparam int unsigned HALVES     = 2;
    localparam int unsigned KEY_WORDS  = LANES * EDGES * HALVES;

    // Key index for a lane, frame half and data edge.
    function automatic int unsigned key_index(input int unsigned lane,
                                              input int unsigned half,
                                              input int unsigned edge_sel);
        return lane * EDGES + half * (LANES * EDGES) + edge_sel;
    endfunction

endpackage

// File: rtl/marker_detect.sv
module marker_detect
    import ddrchk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic strobe_in,
    input  logic sync_in,
    output logic rise
);

    logic mkr_now;
    logic prev_d, prev_q;

    always_comb begin
        mkr_now = (marker_sel_e'(sel) == MKR_SYNC) ? sync_in : strobe_in;
        prev_d  = mkr_now;
        rise    = mkr_now & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R5
    held_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import ddrchk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic rise,
    output logic cmp_valid,
    output logic cmp_half,
    output logic wipe
);

    seq_state_t st_d, st_q;
    logic       fresh;

    always_comb begin
        st_d       = st_q;
        st_d.en_prev = en;
        fresh      = en & ~st_q.en_prev;
        wipe       = clr | fresh;
        cmp_valid  = 1'b0;
        cmp_half   = 1'b0;
        if (!en || wipe) begin
            st_d.armed = 1'b0;
            st_d.phase = 1'b0;
        end else if (rise) begin
            cmp_valid  = 1'b1;
            cmp_half   = 1'b0;
            st_d.armed = 1'b1;
            st_d.phase = 1'b1;
        end else if (st_q.armed) begin
            cmp_valid  = 1'b1;
            cmp_half   = st_q.phase;
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    disarm_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !st_q.armed);

    // R3
    marker_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wipe && rise) |-> (cmp_valid && !cmp_half));

    // R4
    half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wipe && !rise && st_q.armed) |=> (st_q.phase != $past(st_q.phase)));

    // R8
    wipe_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> !st_q.armed);

endmodule

// File: rtl/lane_compare.sv
module lane_compare
    import ddrchk_pkg::*;
#(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned LANE_IDX = 0,
    localparam int unsigned KEY_W   = KEY_WORDS * WORD_W
) (
    input  logic [KEY_W-1:0]  key_words,
    input  logic              half,
    input  logic [WORD_W-1:0] word_rise,
    input  logic [WORD_W-1:0] word_fall,
    output logic [WORD_W-1:0] bit_err
);

    logic [EDGES-1:0][WORD_W-1:0] got;
    logic [EDGES-1:0][WORD_W-1:0] want;
    logic [EDGES-1:0][WORD_W-1:0] diff;

    assign got[0] = word_rise;
    assign got[1] = word_fall;

    for (genvar e = 0; e < EDGES; e++) begin : g_edge
        localparam int unsigned IDX_H0 = key_index(LANE_IDX, 0, e);
        localparam int unsigned IDX_H1 = key_index(LANE_IDX, 1, e);
        always_comb begin
            want[e] = half ? key_words[IDX_H1*WORD_W +: WORD_W]
                           : key_words[IDX_H0*WORD_W +: WORD_W];
            diff[e] = got[e] ^ want[e];
        end
    end

    always_comb begin
        bit_err = '0;
        for (int e = 0; e < EDGES; e++) bit_err |= diff[e];
    end

endmodule

// File: rtl/error_accum.sv
module error_accum
    import ddrchk_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wipe,
    input  logic                         cmp_valid,
    input  logic [LANES-1:0][WORD_W-1:0] lane_err,
    output logic [WORD_W-1:0]            mask,
    output logic                         alarm
);

    typedef struct packed {
        logic [WORD_W-1:0] mask;
        logic              alarm;
    } acc_t;

    acc_t              acc_d, acc_q;
    logic [WORD_W-1:0] folded;

    always_comb begin
        folded = '0;
        for (int l = 0; l < LANES; l++) folded |= lane_err[l];
        acc_d = acc_q;
        if (wipe) begin
            acc_d = '0;
        end else if (cmp_valid) begin
            acc_d.mask  = acc_q.mask | folded;
            acc_d.alarm = acc_q.alarm | (|folded);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign mask  = acc_q.mask;
    assign alarm = acc_q.alarm;

    // R6
    sticky_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wipe |=> ((acc_q.mask & $past(acc_q.mask)) == $past(acc_q.mask)));

    // R7
    alarm_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q.alarm |-> (|acc_q.mask));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid && !wipe) |=> $stable(acc_q));

    // R8
    wipe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (acc_q == '0));

endmodule

// File: rtl/ddr_pattern_checker.sv
module ddr_pattern_checker
    import ddrchk_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned KEY_W = KEY_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              marker_sel,
    input  logic              strobe_in,
    input  logic              sync_in,
    input  logic              clear,
    input  logic [KEY_W-1:0]  key_words,
    input  logic [WORD_W-1:0] bus_a_rise,
    input  logic [WORD_W-1:0] bus_a_fall,
    input  logic [WORD_W-1:0] bus_b_rise,
    input  logic [WORD_W-1:0] bus_b_fall,
    output logic [WORD_W-1:0] err_mask,
    output logic              alarm,
    output logic              analog_off,
    output logic              other_alarms_valid
);

    logic                         mkr_rise;
    logic                         cmp_valid;
    logic                         cmp_half;
    logic                         wipe;
    logic [LANES-1:0][WORD_W-1:0] lane_rise;
    logic [LANES-1:0][WORD_W-1:0] lane_fall;
    logic [LANES-1:0][WORD_W-1:0] lane_err;

    assign lane_rise[0] = bus_a_rise;
    assign lane_fall[0] = bus_a_fall;
    assign lane_rise[1] = bus_b_rise;
    assign lane_fall[1] = bus_b_fall;

    marker_detect u_marker (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (marker_sel),
        .strobe_in (strobe_in),
        .sync_in   (sync_in),
        .rise      (mkr_rise)
    );

    frame_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (test_en),
        .clr       (clear),
        .rise      (mkr_rise),
        .cmp_valid (cmp_valid),
        .cmp_half  (cmp_half),
        .wipe      (wipe)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_compare #(
            .WORD_W   (WORD_W),
            .LANE_IDX (l)
        ) u_cmp (
            .key_words (key_words),
            .half      (cmp_half),
            .word_rise (lane_rise[l]),
            .word_fall (lane_fall[l]),
            .bit_err   (lane_err[l])
        );
    end

    error_accum #(
        .WORD_W (WORD_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe      (wipe),
        .cmp_valid (cmp_valid),
        .lane_err  (lane_err),
        .mask      (err_mask),
        .alarm     (alarm)
    );

    assign analog_off         = test_en;
    assign other_alarms_valid = ~test_en;

    // R9
    masking_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        analog_off != other_alarms_valid);

endmodule

// File: tb/ddr_pattern_checker_bench.sv
module ddr_pattern_checker_bench;

    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           test_en = 1'b0;
    logic           marker_sel = 1'b0;
    logic           strobe_in = 1'b0;
    logic           sync_in = 1'b0;
    logic           clear = 1'b0;
    logic [8*W-1:0] key_words;
    logic [W-1:0]   bus_a_rise = '0, bus_a_fall = '0, bus_b_rise = '0, bus_b_fall = '0;
    logic [W-1:0]   err_mask;
    logic           alarm, analog_off, other_alarms_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ddr_pattern_checker u_ddr_pattern_checker (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .marker_sel(marker_sel),
        .strobe_in(strobe_in), .sync_in(sync_in), .clear(clear),
        .key_words(key_words), .bus_a_rise(bus_a_rise), .bus_a_fall(bus_a_fall),
        .bus_b_rise(bus_b_rise), .bus_b_fall(bus_b_fall), .err_mask(err_mask),
        .alarm(alarm), .analog_off(analog_off), .other_alarms_valid(other_alarms_valid)
    );

    function automatic logic [W-1:0] kw(input int k);
        return key_words[k*W +: W];
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive correct words for half h, flipping bits 'flip' in slot s (0..3, -1 none).
    task automatic put(input int h, input int s, input logic [W-1:0] flip);
        bus_a_rise = kw(4*h + 0) ^ ((s == 0) ? flip : '0);
        bus_a_fall = kw(4*h + 1) ^ ((s == 1) ? flip : '0);
        bus_b_rise = kw(4*h + 2) ^ ((s == 2) ? flip : '0);
        bus_b_fall = kw(4*h + 3) ^ ((s == 3) ? flip : '0);
    endtask

    task automatic set_marker(input logic v);
        if (marker_sel) sync_in = v;
        else            strobe_in = v;
    endtask

    task automatic do_clear();
        clear = 1'b1; tick(); clear = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        for (int k = 0; k < 8; k++) key_words[k*W +: W] = 16'(k * 16'h1357 + 16'h0F1E);
        @(negedge clk); @(negedge clk);
        // reset state
        chk("R6 reset mask", err_mask, '0);
        chk("R7 reset alarm", {15'b0, alarm}, 16'h0);
        rst_n = 1'b1;
        tick();
        chk("R9 off when disabled", {14'b0, analog_off, other_alarms_valid}, 16'h1);

        // R3: errors before any marker are not recorded
        test_en = 1'b1; tick();
        chk("R9 off when enabled", {14'b0, analog_off, other_alarms_valid}, 16'h2);
        for (int c = 0; c < 3; c++) begin put(c % 2, c % 4, 16'hFFFF); tick(); end
        chk("R3 no compare before marker", err_mask, '0);

        // R1 R4 R2 R6 R7: sweep every key slot and bit, both markers
        for (int k = 0; k < 8; k++) begin
            for (int b = 0; b < W; b++) begin
                marker_sel = b[0];
                strobe_in = 1'b0; sync_in = 1'b0;
                do_clear();
                for (int c = 0; c < 6; c++) begin
                    int tgt;
                    tgt = (k / 4) + 2 * (b % 3);
                    set_marker(c == 0);
                    put(c % 2, (c == tgt) ? (k % 4) : -1, 16'(1 << b));
                    tick();
                end
                set_marker(1'b0);
                chk($sformatf("R1 R4 R6 slot %0d bit %0d", k, b), err_mask, 16'(1 << b));
                chk("R7 alarm after error", {15'b0, alarm}, 16'h1);
            end
        end

        // R8: clear wipes
        do_clear();
        chk("R8 clear mask", err_mask, '0);
        chk("R8 clear alarm", {15'b0, alarm}, 16'h0);

        // R2: unselected line ignored (strobe selected, pulse sync)
        marker_sel = 1'b0; strobe_in = 1'b0; sync_in = 1'b0;
        do_clear();
        sync_in = 1'b1; put(0, 0, 16'h00F0); tick();
        sync_in = 1'b0; put(1, 1, 16'h0F00); tick();
        put(0, 2, 16'h000F); tick();
        chk("R2 unselected marker ignored", err_mask, '0);

        // R5: held marker does not retrigger
        strobe_in = 1'b1;
        for (int c = 0; c < 6; c++) begin put(c % 2, -1, '0); tick(); end
        chk("R5 held marker no restart", err_mask, '0);
        // R5: fresh rise mid-frame restarts at half 0
        strobe_in = 1'b0; put(0, -1, '0); tick();   // half 0 of running frame
        strobe_in = 1'b1; put(0, -1, '0); tick();   // would be half 1 without restart
        strobe_in = 1'b0; put(1, -1, '0); tick();
        put(0, -1, '0); tick();
        chk("R5 restart at half 0", err_mask, '0);

        // R6 sticky across later correct data, then R10 hold while disabled
        put(1, 3, 16'h8001); tick();
        put(0, -1, '0); tick(); put(1, -1, '0); tick();
        chk("R6 sticky mask", err_mask, 16'h8001);
        test_en = 1'b0;
        strobe_in = 1'b0; tick();
        strobe_in = 1'b1; put(0, 0, 16'h7FFE); tick();
        put(1, 1, 16'h7FFE); tick();
        chk("R10 hold while disabled", err_mask, 16'h8001);
        chk("R10 alarm hold", {15'b0, alarm}, 16'h1);
        chk("R9 released", {14'b0, analog_off, other_alarms_valid}, 16'h1);

        // R8: fresh enable wipes and disarms
        strobe_in = 1'b1;
        test_en = 1'b1; put(0, 0, 16'h0001); tick();
        chk("R8 fresh enable wipes", err_mask, '0);
        put(1, 0, 16'h0002); tick();
        chk("R8 disarmed after enable", err_mask, '0);

        summary();
    end

endmodule